// File: doc/BRIEF.md
# Memory Fence Ordering Unit

This unit sits beside the issue stage of a simple in-order memory pipeline and enforces the ordering that FENCE and FENCE.I instructions ask for. Every data access the pipeline issues belongs to one of four classes: device input, device output, memory read and memory write. For each class the unit keeps a count of accesses that have been issued but have not yet completed. The pipeline presents each access on a request port and issues it only while the unit grants it.

When a FENCE is accepted, the unit records how many accesses in each predecessor class are still outstanding. Requests in the successor classes are then held back until exactly those accesses have completed. Later accesses in predecessor classes do not lengthen the wait. A FENCE.I waits for earlier memory writes to drain and then raises a one-cycle instruction-cache invalidate together with a pipeline flush request. While a fence of either kind is pending, the unit holds back the next instruction.

A run-time total-store-order input adds acquire behaviour to loads and release behaviour to stores and atomics. In that mode, memory-only fences that cannot add any ordering are dropped. A build parameter selects a conservative variant in which every FENCE orders all four classes against all four.

Top module: `mem_fence_unit`

## Requirements
- R1: After reset, `ins_ready` is 1, `flush_req` and `icache_inval` are 0, and every request class is granted.
- R2: A FENCE is an instruction with bits [6:0] = 0001111 and bits [14:12] = 000. Bits 27, 26, 25 and 24 mark device input, device output, memory read and memory write as predecessors. Bits 23, 22, 21 and 20 mark the same four classes, in the same order, as successors. On `req_class`, 0 is device input, 1 is device output, 2 is memory read and 3 is memory write.
- R3: Once a FENCE is accepted, a request in a successor class gets `req_ready` 0 until every predecessor-class access that was outstanding at acceptance has completed. An access issued in the acceptance cycle counts as earlier. Classes outside the successor set are still granted, and predecessor accesses issued after the fence do not prolong the stall.
- R4: For a FENCE, bits [31:28], [19:15] and [11:7] have no effect. For FENCE.I (bits [14:12] = 001), bits [31:15] and [11:7] have no effect. An instruction with any other opcode or funct3 changes nothing.
- R5: FENCE.I waits until every memory write outstanding at acceptance has completed. It then drives `flush_req` and `icache_inval` high together for exactly one cycle, and it never stalls data requests.
- R6: `ins_ready` is 0 from the cycle after a fence is accepted until one cycle after its predecessor accesses have drained.
- R7: With `tso_en` = 1, a FENCE that names no device class and lacks either the memory-write predecessor or the memory-read successor is ignored: it causes no stall and `ins_ready` stays 1.
- R8: With `tso_en` = 1, no request of any class is granted while a memory read (including an atomic) is outstanding.
- R9: With `tso_en` = 1, a memory write, or an atomic (class 2 with `req_amo` = 1), is granted only when no access of any class is outstanding.
- R10: A class with 2^CNT_W-1 outstanding accesses refuses further requests, and a completion pulse for a class with none outstanding is ignored.
- R11: With CONSERVATIVE = 1, every FENCE uses all four classes as both predecessors and successors, whatever its set bits say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tso_en | input | 1 | Total-store-order mode enable |
| ins_valid | input | 1 | An instruction is offered at issue |
| ins_word | input | 32 | Instruction encoding |
| ins_ready | output | 1 | Instruction may issue (no fence pending) |
| req_valid | input | 1 | A data access wants to issue |
| req_class | input | 2 | Class of the access (0 dev in, 1 dev out, 2 mem read, 3 mem write) |
| req_amo | input | 1 | Access is an atomic read-modify-write (with class 2) |
| req_ready | output | 1 | Access may issue this cycle |
| cpl | input | 4 | Completion pulse per class, bit index = class code |
| flush_req | output | 1 | Pipeline flush request after FENCE.I |
| icache_inval | output | 1 | Instruction-cache invalidate after FENCE.I |

## Verification
The bench builds two copies of the unit and drives both with the same stimulus. One copy uses the default parameters: a 4-bit count per class, so the refusal at 15 outstanding accesses can be reached, and selective fencing. The other copy uses CONSERVATIVE = 1 and CNT_W = 2, so every fence orders all classes and a class saturates after only three accesses. This makes the cap and the full-fence behaviour visible within a few cycles. Directed phases and a long random phase, which toggles the total-store-order input, are compared on every cycle against a behavioural model of each copy.

// File: rtl/mfu_pkg.sv
package mfu_pkg;

    localparam int NUM_CLS = 4;

    typedef enum logic [1:0] {
        CLS_DIN  = 2'd0,
        CLS_DOUT = 2'd1,
        CLS_MRD  = 2'd2,
        CLS_MWR  = 2'd3
    } acc_cls_e;

    localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;
    localparam logic [2:0] F3_FENCE     = 3'b000;
    localparam logic [2:0] F3_FENCEI    = 3'b001;

    typedef struct packed {
        logic                is_fencei;
        logic [NUM_CLS-1:0]  pred;
        logic [NUM_CLS-1:0]  succ;
    } mfu_dec_t;

    typedef struct packed {
        logic                act;
        logic [NUM_CLS-1:0]  succ;
        logic                isfi;
        logic                flush;
    } mfu_ctl_t;

endpackage

// File: rtl/mfu_decode.sv
module mfu_decode
    import mfu_pkg::*;
#(
    parameter bit CONSERVATIVE = 1'b0
) (
    input  logic [31:0] ins_word,
    input  logic        tso_en,
    output mfu_dec_t    dec,
    output logic        arms
);

    logic [NUM_CLS-1:0] raw_pred, raw_succ, pred_sel, succ_sel;
    logic opc_hit, f_fence, f_fencei, io_any, tso_skip;
    logic unused_fields;

    // class c maps to bit 27-c (predecessor) and 23-c (successor)
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_bits
        assign raw_pred[c] = ins_word[27-c];
        assign raw_succ[c] = ins_word[23-c];
    end

    if (CONSERVATIVE) begin : g_cons
        assign pred_sel = '1;
        assign succ_sel = '1;
    end else begin : g_sel
        assign pred_sel = raw_pred;
        assign succ_sel = raw_succ;
    end

    assign unused_fields = ^{ins_word[31:28], ins_word[19:15], ins_word[11:7],
                             raw_pred, raw_succ};

    always_comb begin
        opc_hit  = (ins_word[6:0] == OPC_MISC_MEM);
        f_fence  = opc_hit && (ins_word[14:12] == F3_FENCE);
        f_fencei = opc_hit && (ins_word[14:12] == F3_FENCEI);
        io_any   = pred_sel[CLS_DIN] | pred_sel[CLS_DOUT] |
                   succ_sel[CLS_DIN] | succ_sel[CLS_DOUT];
        // memory-only fence adds nothing under TSO unless W->R is ordered
        tso_skip = tso_en && !io_any && !(pred_sel[CLS_MWR] && succ_sel[CLS_MRD]);
        arms     = (f_fence && !tso_skip) || f_fencei;
        dec.is_fencei = f_fencei;
        dec.pred      = f_fencei ? 4'b1000 : pred_sel;
        dec.succ      = f_fencei ? 4'b0000 : succ_sel;
    end

endmodule

// File: rtl/mfu_class_ctr.sv
module mfu_class_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             done,
    input  logic             arm,
    input  logic             arm_sel,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             drained
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pend;
    } ctr_t;

    ctr_t st_d, st_q;
    logic take;

    always_comb begin
        st_d    = st_q;
        take    = done && (st_q.cnt != '0);
        st_d.cnt = st_q.cnt + CNT_W'(inc) - CNT_W'(take);
        if (arm) begin
            // snapshot includes an access issued in the arming cycle
            st_d.pend = arm_sel ? st_d.cnt : '0;
        end else if (done && (st_q.pend != '0)) begin
            st_d.pend = st_q.pend - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign full    = (st_q.cnt == {CNT_W{1'b1}});
    assign empty   = (st_q.cnt == '0);
    assign drained = (st_q.pend == '0);

endmodule

// File: rtl/mem_fence_unit.sv
module mem_fence_unit
    import mfu_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter bit CONSERVATIVE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tso_en,
    input  logic        ins_valid,
    input  logic [31:0] ins_word,
    output logic        ins_ready,
    input  logic        req_valid,
    input  logic [1:0]  req_class,
    input  logic        req_amo,
    output logic        req_ready,
    input  logic [3:0]  cpl,
    output logic        flush_req,
    output logic        icache_inval
);

    localparam int NC = NUM_CLS;

    mfu_dec_t            dec;
    logic                arms;
    logic [NC-1:0]       sel, inc, full, empty, drained;
    logic [NC*CNT_W-1:0] cnt_flat;
    mfu_ctl_t            st_d, st_q;
    logic                accept, fence_blk, cap_blk, tso_blk, strict_req;
    logic                fence_wait;
    logic [NC-1:0]       wait_succ;

    mfu_decode #(.CONSERVATIVE(CONSERVATIVE)) u_dec (
        .ins_word (ins_word),
        .tso_en   (tso_en),
        .dec      (dec),
        .arms     (arms)
    );

    for (genvar c = 0; c < NC; c++) begin : g_cls
        assign sel[c] = (req_class == 2'(c));
        assign inc[c] = req_valid && req_ready && sel[c];
        mfu_class_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc[c]),
            .done    (cpl[c]),
            .arm     (accept),
            .arm_sel (dec.pred[c]),
            .count   (cnt_flat[c*CNT_W +: CNT_W]),
            .full    (full[c]),
            .empty   (empty[c]),
            .drained (drained[c])
        );
    end

    always_comb begin
        fence_blk  = st_q.act && |(st_q.succ & sel);
        cap_blk    = |(full & sel);
        strict_req = (req_class == CLS_MWR) || (req_amo && (req_class == CLS_MRD));
        tso_blk    = tso_en && (!empty[CLS_MRD] || (strict_req && !(&empty)));
        req_ready  = !(fence_blk || cap_blk || tso_blk);
        ins_ready  = !st_q.act;
        accept     = ins_valid && ins_ready && arms;

        st_d       = st_q;
        st_d.flush = 1'b0;
        if (st_q.act && (&drained)) begin
            st_d.act   = 1'b0;
            st_d.flush = st_q.isfi;
        end
        if (accept) begin
            st_d.act  = 1'b1;
            st_d.succ = dec.succ;
            st_d.isfi = dec.is_fencei;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush_req    = st_q.flush;
    assign icache_inval = st_q.flush;
    assign fence_wait   = st_q.act;
    assign wait_succ    = st_q.succ;

endmodule

// File: rtl/mem_fence_unit_chk.sv
module mem_fence_unit_chk #(
    parameter int CNT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tso_en,
    input logic               ins_valid,
    input logic               ins_ready,
    input logic               req_valid,
    input logic [1:0]         req_class,
    input logic               req_ready,
    input logic               flush_req,
    input logic [4*CNT_W-1:0] cnt_flat,
    input logic               fence_wait,
    input logic [3:0]         wait_succ,
    input logic               arms
);

    a_r3_succ_stall: assert property (@(posedge clk) disable iff (!rst_n)
        fence_wait && req_valid && wait_succ[req_class] |-> !req_ready);

    a_r5_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);

    a_r6_hold_instr: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_ready && arms |=> !ins_ready);

    a_r8_tso_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        tso_en && req_valid && (cnt_flat[2*CNT_W +: CNT_W] != '0) |-> !req_ready);

    a_r9_tso_release: assert property (@(posedge clk) disable iff (!rst_n)
        tso_en && req_valid && (req_class == 2'd3) && (|cnt_flat) |-> !req_ready);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |->
            cnt_flat[int'(req_class)*CNT_W +: CNT_W] != {CNT_W{1'b1}});

endmodule

bind mem_fence_unit mem_fence_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tso_en     (tso_en),
    .ins_valid  (ins_valid),
    .ins_ready  (ins_ready),
    .req_valid  (req_valid),
    .req_class  (req_class),
    .req_ready  (req_ready),
    .flush_req  (flush_req),
    .cnt_flat   (cnt_flat),
    .fence_wait (fence_wait),
    .wait_succ  (wait_succ),
    .arms       (arms)
);

// File: tb/mem_fence_unit_test.sv
`timescale 1ns/1ps
module mem_fence_unit_test;

    logic        clk = 1'b0, rst_n = 1'b0, tso_en = 1'b0;
    logic        ins_valid = 1'b0, req_valid = 1'b0, req_amo = 1'b0;
    logic [31:0] ins_word = '0;
    logic [1:0]  req_class = '0;
    logic [3:0]  cpl = '0;
    logic        o_irdy [2];
    logic        o_rdy  [2];
    logic        o_fl   [2];
    logic        o_inv  [2];

    mem_fence_unit uut (
        .clk(clk), .rst_n(rst_n), .tso_en(tso_en), .ins_valid(ins_valid),
        .ins_word(ins_word), .ins_ready(o_irdy[0]), .req_valid(req_valid),
        .req_class(req_class), .req_amo(req_amo), .req_ready(o_rdy[0]),
        .cpl(cpl), .flush_req(o_fl[0]), .icache_inval(o_inv[0])
    );

    mem_fence_unit #(.CNT_W(2), .CONSERVATIVE(1'b1)) uut_cons (
        .clk(clk), .rst_n(rst_n), .tso_en(tso_en), .ins_valid(ins_valid),
        .ins_word(ins_word), .ins_ready(o_irdy[1]), .req_valid(req_valid),
        .req_class(req_class), .req_amo(req_amo), .req_ready(o_rdy[1]),
        .cpl(cpl), .flush_req(o_fl[1]), .icache_inval(o_inv[1])
    );

    always #10 clk = ~clk;

    // behavioural reference state per instance
    int       m_cnt  [2][4];
    int       m_pend [2][4];
    bit       m_act  [2];
    bit       m_isfi [2];
    bit       m_fl   [2];
    bit [3:0] m_succ [2];
    bit       e_rdy  [2];
    int       m_max  [2] = '{15, 3};
    bit       m_cons [2] = '{1'b0, 1'b1};
    int       total = 0, bad = 0;
    string    cur_req = "R1";

    function automatic logic [31:0] mkf(input bit [3:0] p, input bit [3:0] s,
                                        input bit [2:0] f3);
        return {4'b0, p, s, 5'b0, f3, 5'b0, 7'b0001111};
    endfunction

    task automatic decode_m(input int i, output bit arms, output bit [3:0] p,
                            output bit [3:0] s, output bit fi);
        bit opc, ff, io;
        opc = (ins_word[6:0] == 7'b0001111);
        ff  = opc && (ins_word[14:12] == 3'b000);
        fi  = opc && (ins_word[14:12] == 3'b001);
        for (int c = 0; c < 4; c++) begin
            p[c] = ins_word[27-c];
            s[c] = ins_word[23-c];
        end
        if (m_cons[i]) begin p = 4'hF; s = 4'hF; end
        io   = p[0] | p[1] | s[0] | s[1];
        arms = fi || (ff && !(tso_en && !io && !(p[3] && s[2])));
        if (fi) begin p = 4'b1000; s = 4'b0000; end
    endtask

    function automatic bit exp_ready(input int i);
        int tot = 0;
        for (int c = 0; c < 4; c++) tot += m_cnt[i][c];
        if (m_act[i] && m_succ[i][req_class]) return 1'b0;
        if (m_cnt[i][req_class] == m_max[i]) return 1'b0;
        if (tso_en) begin
            if (m_cnt[i][2] != 0) return 1'b0;
            if (((req_class == 2'd3) || ((req_class == 2'd2) && req_amo)) && tot != 0)
                return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(input string nm, input int i, input logic got, input bit exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s inst%0d %s got=%0b exp=%0b", cur_req, i, nm, got, exp);
        end
    endtask

    task automatic model_step(input int i);
        bit arms, fi, alld, fire, arm, nfl;
        bit [3:0] p, s;
        int nc;
        decode_m(i, arms, p, s, fi);
        fire = req_valid && e_rdy[i];
        arm  = ins_valid && !m_act[i] && arms;
        alld = 1'b1;
        for (int c = 0; c < 4; c++) if (m_pend[i][c] != 0) alld = 1'b0;
        for (int c = 0; c < 4; c++) begin
            nc = m_cnt[i][c] + ((fire && req_class == 2'(c)) ? 1 : 0)
                 - ((cpl[c] && m_cnt[i][c] != 0) ? 1 : 0);
            if (arm) m_pend[i][c] = p[c] ? nc : 0;
            else if (cpl[c] && m_pend[i][c] != 0) m_pend[i][c]--;
            m_cnt[i][c] = nc;
        end
        nfl = 1'b0;
        if (m_act[i] && alld) begin m_act[i] = 1'b0; nfl = m_isfi[i]; end
        if (arm) begin m_act[i] = 1'b1; m_succ[i] = s; m_isfi[i] = fi; end
        m_fl[i] = nfl;
    endtask

    task automatic cyc();
        #2;
        for (int i = 0; i < 2; i++) begin
            e_rdy[i] = exp_ready(i);
            chk("ins_ready", i, o_irdy[i], !m_act[i]);
            chk("req_ready", i, o_rdy[i], e_rdy[i]);
            chk("flush_req", i, o_fl[i], m_fl[i]);
            chk("icache_inval", i, o_inv[i], m_fl[i]);
        end
        @(posedge clk);
        for (int i = 0; i < 2; i++) model_step(i);
        @(negedge clk);
    endtask

    task automatic drv(input bit iv, input logic [31:0] w, input bit rv,
                       input int cls, input bit amo, input logic [3:0] c);
        ins_valid = iv; ins_word = w; req_valid = rv;
        req_class = cls[1:0]; req_amo = amo; cpl = c;
        cyc();
    endtask

    task automatic idle(input int n);
        repeat (n) drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'h0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=hang exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle state after reset, every class granted
        cur_req = "R1";
        for (int c = 0; c < 4; c++) drv(1'b0, 32'h0, 1'b1, c, 1'b0, 4'h0);
        // the grants above issued one access per class; drain them
        drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'hF);

        // R2 R3: two writes, then FENCE W -> R; R11 on the conservative copy
        cur_req = "R3";
        drv(1'b0, 32'h0, 1'b1, 3, 1'b0, 4'h0);
        drv(1'b1, mkf(4'b0001, 4'b0010, 3'b000), 1'b1, 3, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 2, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 0, 1'b0, 4'h0);
        cur_req = "R11";
        drv(1'b0, 32'h0, 1'b1, 3, 1'b0, 4'h0);
        cur_req = "R6";
        drv(1'b1, mkf(4'b1111, 4'b1111, 3'b000), 1'b1, 2, 1'b0, 4'b1000);
        drv(1'b0, 32'h0, 1'b1, 2, 1'b0, 4'b1001);
        drv(1'b0, 32'h0, 1'b1, 2, 1'b0, 4'b1000);
        drv(1'b0, 32'h0, 1'b1, 2, 1'b0, 4'b1000);
        idle(2);
        drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'hF);

        // R4: ignored fields and non-fence encodings
        cur_req = "R4";
        drv(1'b0, 32'h0, 1'b1, 1, 1'b0, 4'h0);
        drv(1'b1, mkf(4'b0100, 4'b1000, 3'b000) | 32'hF00F8F80, 1'b0, 0, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 0, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 0, 1'b0, 4'b0010);
        idle(3);
        drv(1'b1, mkf(4'b1111, 4'b1111, 3'b010), 1'b1, 3, 1'b0, 4'h0);
        drv(1'b1, mkf(4'b1111, 4'b1111, 3'b000) ^ 32'h0000_0040, 1'b1, 2, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'hF);
        idle(2);

        // R5: FENCE.I waits for writes, then one flush pulse
        cur_req = "R5";
        drv(1'b0, 32'h0, 1'b1, 3, 1'b0, 4'h0);
        drv(1'b1, mkf(4'b1111, 4'b1111, 3'b001) | 32'hF00F8F80, 1'b1, 2, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 0, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'b1000);
        idle(4);
        drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'hF);
        drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'hF);

        // R7: TSO drops memory-only fences lacking W->R
        cur_req = "R7";
        tso_en = 1'b1;
        drv(1'b1, mkf(4'b0010, 4'b0001, 3'b000), 1'b0, 0, 1'b0, 4'h0);
        drv(1'b1, mkf(4'b0011, 4'b0011, 3'b000), 1'b0, 0, 1'b0, 4'h0);
        drv(1'b1, mkf(4'b0001, 4'b0010, 3'b000), 1'b0, 0, 1'b0, 4'h0);
        idle(3);

        // R8: an outstanding read holds back every class
        cur_req = "R8";
        drv(1'b0, 32'h0, 1'b1, 2, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 1, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 0, 1'b0, 4'b0100);
        drv(1'b0, 32'h0, 1'b1, 1, 1'b0, 4'h0);

        // R9: stores and atomics wait for everything
        cur_req = "R9";
        drv(1'b0, 32'h0, 1'b1, 3, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 2, 1'b1, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 2, 1'b1, 4'b0011);
        drv(1'b0, 32'h0, 1'b1, 2, 1'b1, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 3, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 3, 1'b0, 4'b0100);
        drv(1'b0, 32'h0, 1'b1, 3, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'hF);
        tso_en = 1'b0;

        // R10: saturation and spurious completions
        cur_req = "R10";
        repeat (17) drv(1'b0, 32'h0, 1'b1, 0, 1'b0, 4'h0);
        drv(1'b0, 32'h0, 1'b1, 1, 1'b0, 4'b0010);
        drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'b1100);
        drv(1'b0, 32'h0, 1'b1, 3, 1'b0, 4'h0);
        repeat (16) drv(1'b0, 32'h0, 1'b0, 0, 1'b0, 4'hF);

        // mixed traffic covering R2 R3 R6 R8 R9 R11
        cur_req = "R2";
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] w;
            if ((k % 500) == 0) tso_en = ~tso_en;
            if (k == 1500) cur_req = "R3";
            w = $urandom;
            if (($urandom % 4) != 0) w[6:0] = 7'b0001111;
            if (($urandom % 3) != 0) w[14:12] = {2'b00, 1'($urandom % 2)};
            drv(($urandom % 6) == 0, w, ($urandom % 2) == 1, int'($urandom % 4),
                ($urandom % 4) == 0, 4'($urandom));
        end
        finish_run();
    end

endmodule